// File: doc/BRIEF.md
# Narrow Slave Wide-Bus Adapter

This block lets a slave whose data interface is 32 bits wide sit on a 64-bit pipelined system bus without any change inside the slave. Address, control and the handshake go straight through to the inner slave. Only the data paths are adapted. A one-bit lane register records address bit 2 in each accepted address phase. In the data phase that follows, that bit selects which 32-bit half of the wide bus feeds the slave's write port and which half carries its read data.

Read data is placed on the wide bus in one of two ways, chosen at compile time. The first copies the 32-bit word onto both halves. The second changes only the selected half and holds the other, which saves switching power. The adapter also refuses any transfer that is wider than the slave's natural 32-bit width: it gives a two-cycle error response and never passes that transfer to the slave. A small byte-writable register file stands in for the inner slave.

Top module: `wide_port_adapter`

## Requirements
- R1: While reset is asserted (active-low `rst_n`, which may drop at any time and is released on a clock edge), and after it, the block presents `bus_ready_out`=1, `bus_resp`=2'b00 (OKAY) and `bus_rdata`=0.
- R2: The lane bit is sampled from `bus_addr[2]` only on edges where `bus_ready_in` is 1. It is used in the data phase that follows, even if a later, pipelined address phase carries a different bit 2.
- R3: Write data reaches the slave from `bus_wdata[31:0]` when the lane bit is 0 and from `bus_wdata[63:32]` when it is 1. The other half has no effect.
- R4: With REPLICATE=1, a 32-bit read word appears on both `bus_rdata[31:0]` and `bus_rdata[63:32]` in the read data phase.
- R5: With REPLICATE=0, a read drives its word only on the half chosen by the lane bit. The other half keeps its previous value, and both halves are 0 after reset.
- R6: A transfer is oversized when `bus_sel`=1, `bus_trans[1]`=1 (NONSEQ 2'b10 or SEQ 2'b11) and `bus_size`>=3'd3 (64 bits or more). An oversized address phase accepted with `bus_ready_in`=1 is answered with `bus_ready_out`=0 and `bus_resp`=2'b01 (ERROR) in the next cycle. In the cycle after that, `bus_ready_out`=1 and `bus_resp`=2'b01. OKAY follows once no further oversized transfer is pending.
- R7: An oversized transfer is shown to the slave as IDLE, so an oversized write leaves the stored word unchanged.
- R8: Sizes 3'd0 (byte) and 3'd1 (halfword) write only the addressed bytes. Byte n of the 32-bit word sits on bits 8n+7..8n, where n is `bus_addr[1:0]` for a byte, and `bus_addr[1]` selects bytes 2..3 or 0..1 for a halfword. Size 3'd2 writes all four bytes.
- R9: A transfer that is not oversized completes with no wait state: `bus_ready_out`=1 and `bus_resp`=2'b00 in its data phase.
- R10: A transfer with `bus_trans`=2'b00 (IDLE) or with `bus_sel`=0 does not change the stored data.
- R11: A read whose address phase coincides with the data phase of a write to the same word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Slave select |
| bus_addr | input | ADDR_W | Byte address |
| bus_trans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| bus_size | input | 3 | Transfer size, log2 of the byte count |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 64 | Wide write data |
| bus_ready_in | input | 1 | Bus-wide ready; 1 completes the current data phase |
| bus_rdata | output | 64 | Wide read data |
| bus_ready_out | output | 1 | This slave's ready |
| bus_resp | output | 2 | Response: 00 OKAY, 01 ERROR |

## Verification
On every cycle, the assertions check four things. The lane bit holds while the bus stalls. The error response always runs ready-low, then ready-high. An oversized address phase always starts that response. No oversized transfer ever reaches the inner slave. In hold mode they also check that the unselected read half stays steady.

Some behaviour only the bench's scenarios can show, because it depends on the data values that were stored and then read back. That covers half selection for writes, byte and halfword merging, the refusal of oversized and idle writes, the forwarding of read-after-write data, and the contents of both read modes.

// File: rtl/wpa_pkg.sv
`timescale 1ns/1ps
package wpa_pkg;
  localparam int NARROW_W = 32;
  localparam int WIDE_W   = 2 * NARROW_W;
  localparam int NBYTES   = NARROW_W / 8;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] RSP_OKAY  = 2'b00;
  localparam logic [1:0] RSP_ERROR = 2'b01;
  localparam logic [2:0] SZ_BYTE   = 3'd0;
  localparam logic [2:0] SZ_HALF   = 3'd1;
  localparam logic [2:0] SZ_MAXOK  = 3'd2;

  typedef enum logic [1:0] {
    GD_PASS = 2'd0,
    GD_ERR1 = 2'd1,
    GD_ERR2 = 2'd2
  } guard_state_e;
endpackage

// File: rtl/wpa_lane.sv
`timescale 1ns/1ps
module wpa_lane
  import wpa_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ready_in,
  input  logic                lane_bit,
  input  logic [WIDE_W-1:0]   wdata_wide,
  output logic                lane_q,
  output logic [NARROW_W-1:0] wdata_narrow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lane_q <= 1'b0;
    else if (ready_in) lane_q <= lane_bit;
  end

  assign wdata_narrow = lane_q ? wdata_wide[WIDE_W-1:NARROW_W]
                               : wdata_wide[NARROW_W-1:0];

  // R2
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_in |=> $stable(lane_q))
    else $error("lane bit moved during a stall");
endmodule

// File: rtl/wpa_guard.sv
`timescale 1ns/1ps
module wpa_guard
  import wpa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic [1:0] trans,
  input  logic [2:0] size,
  input  logic       ready_in,
  output logic [1:0] fwd_trans,
  output logic       busy,
  output logic       ready_out,
  output logic [1:0] resp
);
  guard_state_e state_q, state_d;
  logic         oversize;

  assign oversize  = sel && trans[1] && (size > SZ_MAXOK);
  assign fwd_trans = oversize ? TR_IDLE : trans;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GD_PASS: if (ready_in && oversize) state_d = GD_ERR1;
      GD_ERR1: state_d = GD_ERR2;
      GD_ERR2: state_d = (ready_in && oversize) ? GD_ERR1 : GD_PASS;
      default: state_d = GD_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GD_PASS;
    else        state_q <= state_d;
  end

  assign busy      = (state_q != GD_PASS);
  assign ready_out = (state_q != GD_ERR1);
  assign resp      = busy ? RSP_ERROR : RSP_OKAY;

  // R6
  err_second_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp == RSP_ERROR && !ready_out) |=> (resp == RSP_ERROR && ready_out))
    else $error("error response did not finish with ready high");
  // R6
  err_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_in && oversize) |=> (!ready_out && resp == RSP_ERROR))
    else $error("oversized transfer not answered with error");
endmodule

// File: rtl/wpa_regfile.sv
`timescale 1ns/1ps
module wpa_regfile
  import wpa_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          trans,
  input  logic [2:0]          size,
  input  logic                write,
  input  logic                ready_in,
  input  logic [NARROW_W-1:0] wdata,
  output logic [NARROW_W-1:0] rdata,
  output logic                ready_out,
  output logic [1:0]          resp
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int DEPTH = 1 << IDX_W;

  logic              accept;
  logic [IDX_W-1:0]  idx_a;
  logic [NBYTES-1:0] be_a;
  logic              wr_pend_q;
  logic [IDX_W-1:0]  idx_q;
  logic [NBYTES-1:0] be_q;
  logic              wr_now;

  assign accept = sel && trans[1] && ready_in;
  assign idx_a  = addr[ADDR_W-1:2];

  always_comb begin
    if (size == SZ_BYTE)      be_a = NBYTES'(1) << addr[1:0];
    else if (size == SZ_HALF) be_a = addr[1] ? 4'b1100 : 4'b0011;
    else                      be_a = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend_q <= 1'b0;
      idx_q     <= '0;
      be_q      <= '0;
    end else if (ready_in) begin
      wr_pend_q <= accept && write;
      idx_q     <= idx_a;
      be_q      <= be_a;
    end
  end

  assign wr_now = wr_pend_q && ready_in;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rd_q;
    logic       fwd;

    assign fwd = wr_now && be_q[b] && (idx_q == idx_a);

    always_ff @(posedge clk) begin
      if (wr_now && be_q[b]) mem_q[idx_q] <= wdata[8*b +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rd_q <= '0;
      else if (accept && !write)  rd_q <= fwd ? wdata[8*b +: 8] : mem_q[idx_a];
    end

    assign rdata[8*b +: 8] = rd_q;
  end

  assign ready_out = 1'b1;
  assign resp      = RSP_OKAY;

  // R7
  no_wide_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (size <= SZ_MAXOK))
    else $error("oversized transfer reached the slave");
endmodule

// File: rtl/wpa_rd_steer.sv
`timescale 1ns/1ps
module wpa_rd_steer
  import wpa_pkg::*;
#(
  parameter bit REPLICATE = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ready_in,
  input  logic                rd_accept,
  input  logic                lane_q,
  input  logic [NARROW_W-1:0] rdata_narrow,
  output logic [WIDE_W-1:0]   rdata_wide
);
  logic dph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dph_q <= 1'b0;
    else if (ready_in) dph_q <= rd_accept;
  end

  if (REPLICATE) begin : g_copy
    logic unused_sigs;
    assign unused_sigs = ^{dph_q, lane_q};
    assign rdata_wide  = {rdata_narrow, rdata_narrow};
  end else begin : g_hold
    logic [NARROW_W-1:0] half_q [2];
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic act;
      assign act = dph_q && (lane_q == h[0]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               half_q[h] <= '0;
        else if (act && ready_in) half_q[h] <= rdata_narrow;
      end
      assign rdata_wide[h*NARROW_W +: NARROW_W] = act ? rdata_narrow : half_q[h];
    end

    // R5
    idle_half_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dph_q && lane_q) |-> $stable(rdata_wide[NARROW_W-1:0]))
      else $error("low half moved during an upper-half read");
    // R5
    idle_half_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dph_q && !lane_q) |-> $stable(rdata_wide[WIDE_W-1:NARROW_W]))
      else $error("upper half moved during a low-half read");
  end
endmodule

// File: rtl/wide_port_adapter.sv
`timescale 1ns/1ps
module wide_port_adapter
  import wpa_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter bit REPLICATE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_trans,
  input  logic [2:0]        bus_size,
  input  logic              bus_write,
  input  logic [63:0]       bus_wdata,
  input  logic              bus_ready_in,
  output logic [63:0]       bus_rdata,
  output logic              bus_ready_out,
  output logic [1:0]        bus_resp
);
  logic                lane_q;
  logic [NARROW_W-1:0] wdata_n;
  logic [NARROW_W-1:0] rdata_n;
  logic [1:0]          fwd_trans;
  logic                gd_busy, gd_ready;
  logic [1:0]          gd_resp;
  logic                sl_ready;
  logic [1:0]          sl_resp;
  logic                rd_accept;

  wpa_lane u_lane (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready_in     (bus_ready_in),
    .lane_bit     (bus_addr[2]),
    .wdata_wide   (bus_wdata),
    .lane_q       (lane_q),
    .wdata_narrow (wdata_n)
  );

  wpa_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (bus_sel),
    .trans     (bus_trans),
    .size      (bus_size),
    .ready_in  (bus_ready_in),
    .fwd_trans (fwd_trans),
    .busy      (gd_busy),
    .ready_out (gd_ready),
    .resp      (gd_resp)
  );

  wpa_regfile #(.ADDR_W(ADDR_W)) u_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (bus_sel),
    .addr      (bus_addr),
    .trans     (fwd_trans),
    .size      (bus_size),
    .write     (bus_write),
    .ready_in  (bus_ready_in),
    .wdata     (wdata_n),
    .rdata     (rdata_n),
    .ready_out (sl_ready),
    .resp      (sl_resp)
  );

  assign rd_accept = bus_sel && fwd_trans[1] && !bus_write;

  wpa_rd_steer #(.REPLICATE(REPLICATE)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready_in     (bus_ready_in),
    .rd_accept    (rd_accept),
    .lane_q       (lane_q),
    .rdata_narrow (rdata_n),
    .rdata_wide   (bus_rdata)
  );

  assign bus_ready_out = gd_busy ? gd_ready : sl_ready;
  assign bus_resp      = gd_busy ? gd_resp  : sl_resp;
endmodule

// File: tb/test_wide_port_adapter.sv
`timescale 1ns/1ps
module test_wide_port_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  trans = 2'b00;
  logic [2:0]  size = 3'd2;
  logic        write = 1'b0;
  logic [63:0] wdata = '0;
  logic        ready_in;
  logic [63:0] rdata, rdata_rep;
  logic        ready_out, ready_rep;
  logic [1:0]  resp, resp_rep;

  always #5 clk = ~clk;
  assign ready_in = ready_out;

  wide_port_adapter #(.ADDR_W(8), .REPLICATE(1'b0)) i_wide_port_adapter (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_addr(addr), .bus_trans(trans),
    .bus_size(size), .bus_write(write), .bus_wdata(wdata), .bus_ready_in(ready_in),
    .bus_rdata(rdata), .bus_ready_out(ready_out), .bus_resp(resp));

  wide_port_adapter #(.ADDR_W(8), .REPLICATE(1'b1)) i_wide_port_adapter_rep (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_addr(addr), .bus_trans(trans),
    .bus_size(size), .bus_write(write), .bus_wdata(wdata), .bus_ready_in(ready_in),
    .bus_rdata(rdata_rep), .bus_ready_out(ready_rep), .bus_resp(resp_rep));

  typedef struct {
    int          due;
    bit          chk_rd;
    logic [63:0] exp_hold;
    logic [63:0] exp_rep;
    logic        exp_ready;
    logic [1:0]  exp_resp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          cyc = 0;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic [31:0] mdl [64];
  logic [31:0] hold_lo = '0, hold_hi = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops scoreboard items due this cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      bit    bad;
      it  = sb_q.pop_front();
      bad = (ready_out !== it.exp_ready) || (resp !== it.exp_resp) ||
            (ready_rep !== it.exp_ready) || (resp_rep !== it.exp_resp);
      if (it.chk_rd)
        bad = bad || (rdata !== it.exp_hold) || (rdata_rep !== it.exp_rep);
      n_vec++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s: ready=%b resp=%b rdata=%h rep=%h, expected ready=%b resp=%b rdata=%h rep=%h",
                 it.tag, ready_out, resp, rdata, rdata_rep,
                 it.exp_ready, it.exp_resp, it.exp_hold, it.exp_rep);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(bit chk, logic rdy, logic [1:0] rsp, string tag);
    item_t it;
    it.due = cyc; it.chk_rd = chk; it.exp_ready = rdy; it.exp_resp = rsp;
    it.exp_hold = {hold_hi, hold_lo}; it.exp_rep = '0; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic push_rd(logic [7:0] a, string tag);
    item_t       it;
    logic [31:0] w;
    w = mdl[a[7:2]];
    if (a[2]) hold_hi = w; else hold_lo = w;
    it.due = cyc; it.chk_rd = 1; it.exp_ready = 1; it.exp_resp = 2'b00;
    it.exp_hold = {hold_hi, hold_lo}; it.exp_rep = {w, w}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  function automatic void mdl_write(logic [7:0] a, logic [2:0] sz, logic [63:0] d);
    logic [31:0] v;
    logic [3:0]  be;
    v  = a[2] ? d[63:32] : d[31:0];
    be = (sz == 3'd0) ? (4'b0001 << a[1:0]) :
         (sz == 3'd1) ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
    for (int b = 0; b < 4; b++)
      if (be[b]) mdl[a[7:2]][8*b +: 8] = v[8*b +: 8];
  endfunction

  task automatic addr_phase(bit s, logic [1:0] t, logic [7:0] a, logic [2:0] sz, bit w);
    sel = s; trans = t; addr = a; size = sz; write = w;
  endtask

  task automatic idle_phase();
    sel = 0; trans = 2'b00; write = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [2:0] sz, logic [63:0] d, string tag);
    addr_phase(1, 2'b10, a, sz, 1); tick();
    idle_phase(); wdata = d; mdl_write(a, sz, d);
    push(0, 1, 2'b00, tag); tick();
  endtask

  task automatic rd(logic [7:0] a, string tag);
    addr_phase(1, 2'b10, a, 3'd2, 0); tick();
    idle_phase(); wdata = '1;
    push_rd(a, tag); tick();
  endtask

  task automatic oversize(logic [7:0] a, logic [2:0] sz, bit w, string tag);
    addr_phase(1, 2'b10, a, sz, w); tick();
    idle_phase(); wdata = '1;
    push(0, 0, 2'b01, tag); tick();
    push(0, 1, 2'b01, tag); tick();
    push(0, 1, 2'b00, tag); tick();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    repeat (3) tick();
    rst_n = 1'b1; tick();
    // R1: state just after reset
    push(1, 1, 2'b00, "R1 reset state"); tick();

    // initialise words that are read later
    for (int i = 0; i < 8; i++) wr(8'(i * 4), 3'd2, {32'(i) + 32'h100, 32'(i) + 32'h100}, "R9 init write");

    // R3: lane 0 takes the low half, lane 1 the high half
    wr(8'h00, 3'd2, {32'hDEAD_BEEF, 32'h1122_3344}, "R3 low half write");
    wr(8'h04, 3'd2, {32'h5566_7788, 32'hCAFE_F00D}, "R3 high half write");
    // R4 R5 R9: read each lane
    rd(8'h00, "R5 R4 read low lane");
    rd(8'h04, "R5 R4 read high lane");
    rd(8'h00, "R9 reread low lane");

    // R8: byte and halfword merges
    wr(8'h01, 3'd0, {32'hFFFF_FFFF, 32'h0000_AB00}, "R8 byte write");
    rd(8'h00, "R8 byte readback");
    wr(8'h06, 3'd1, {32'h9999_0000, 32'hFFFF_FFFF}, "R8 half write");
    rd(8'h04, "R8 half readback");

    // R6 R7: oversized write and read
    wr(8'h08, 3'd2, {32'h0, 32'h0A0B_0C0D}, "R9 setup write");
    oversize(8'h08, 3'd3, 1, "R6 oversized write");
    rd(8'h08, "R7 oversized write dropped");
    oversize(8'h0C, 3'd4, 0, "R6 oversized read");

    // R6: two oversized back to back; second address phase in the error tail
    addr_phase(1, 2'b10, 8'h08, 3'd3, 1); tick();
    idle_phase(); push(0, 0, 2'b01, "R6 chained first"); tick();
    addr_phase(1, 2'b11, 8'h08, 3'd5, 1); push(0, 1, 2'b01, "R6 chained first"); tick();
    idle_phase(); push(0, 0, 2'b01, "R6 chained second"); tick();
    push(0, 1, 2'b01, "R6 chained second"); tick();
    push(0, 1, 2'b00, "R6 chained done"); tick();
    rd(8'h08, "R7 chained writes dropped");

    // R10: IDLE and deselected writes
    addr_phase(1, 2'b00, 8'h08, 3'd2, 1); tick();
    idle_phase(); wdata = 64'h7777_7777_7777_7777; tick();
    addr_phase(0, 2'b10, 8'h08, 3'd2, 1); tick();
    idle_phase(); wdata = 64'h6666_6666_6666_6666; tick();
    rd(8'h08, "R10 idle and unselected ignored");

    // R2: write to lane 1, pipelined read address on lane 0
    addr_phase(1, 2'b10, 8'h0C, 3'd2, 1); tick();
    addr_phase(1, 2'b10, 8'h10, 3'd2, 0);
    wdata = {32'hA5A5_0001, 32'h5A5A_0002}; mdl_write(8'h0C, 3'd2, wdata);
    push(0, 1, 2'b00, "R2 pipelined write"); tick();
    idle_phase(); push_rd(8'h10, "R2 pipelined read"); tick();
    rd(8'h0C, "R2 lane taken from own address phase");

    // R11: read the word being written in the same cycle
    addr_phase(1, 2'b10, 8'h14, 3'd2, 1); tick();
    addr_phase(1, 2'b10, 8'h14, 3'd2, 0);
    wdata = {32'h0BAD_F00D, 32'h3141_5926}; mdl_write(8'h14, 3'd2, wdata);
    push(0, 1, 2'b00, "R11 write"); tick();
    idle_phase(); push_rd(8'h14, "R11 forwarded read"); tick();

    repeat (3) tick();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule